// File: doc/BRIEF.md
# Bus Master Write Request Sequencer

This block is the user-side engine that opens a bus-master write burst into an embedded PCI core and keeps it fed. When a burst is requested it puts a command word on the core's data path, then an address word, both qualified by an active-low header enable. It then moves to the data phase, where it takes words from a valid/ready user stream and passes each word, with its byte enables, to the core under an active-low write-data enable.

The sequencer holds its own copy of the core's 3-bit master state counter and uses it to pick what to drive in each cycle. It cannot use the core's reported counter for this, because that value arrives in the same cycle as the data it selects. The reported counter is instead compared with the local value from one cycle earlier, and any difference sets a sticky error flag. The block slows down on the core's almost-full and full flags. It can also close a burst that has stalled: an abort request, or a programmable run of idle cycles in the data phase, sends one dummy word with every byte enable off and the last-word marker asserted. Without that word, the core would insert wait states without end.

Top module: `mwr_seq`

## Requirements
- R1: While reset is held, `seq_state` is 0, `hdr_en_n`, `wr_en_n` and `last_n` are 1, `s_ready` is 0 and `state_err` is 0.
- R2: A `start` in state 0 gives one cycle in state 1 (command, `hdr_en_n`=0, `dout`=`cmd_word`), then one cycle in state 2 (address, `hdr_en_n`=0, `dout`=`addr_word`), then state 3 (data) with `hdr_en_n`=1.
- R3: In state 3, `wr_en_n` is 0 exactly in the cycles where `s_valid` and `s_ready` are both 1, and in those cycles `dout`=`s_data` and `be`=`s_be`.
- R4: A transferred beat with `s_last`=1 drives `last_n`=0 in the same cycle, and the next cycle is in state 0.
- R5: `s_ready` is 0 in every cycle where `afull_n`=0 or `full_n`=0, and also in the one cycle right after `afull_n` returns to 1.
- R6: `abort`=1 in state 3 forces `s_ready` to 0 and moves the block to state 4 (last). In state 4 it sends a word with `wr_en_n`=0, `last_n`=0 and `be`=0, and then returns to state 0. Abort takes priority over a last beat offered in the same cycle.
- R7: With `idle_limit`=N and N not 0, N consecutive state-3 cycles with `s_valid`=0 lead to state 4 in the next cycle. With N=0 the idle timeout is disabled.
- R8: In state 4, while the pacing gate of R5 is closed, the dummy word is held back (`wr_en_n`=1, `last_n`=1) and the state stays 4.
- R9: If `core_state` differs from the value `seq_state` had in the previous cycle, `state_err` becomes 1 in the next cycle and stays 1 until reset. Values 5 to 7 are never valid.
- R10: `start` has no effect outside state 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a new write burst |
| cmd_word | input | DW | Command word for the burst |
| addr_word | input | DW | Start address of the burst |
| idle_limit | input | TOW | Idle cycles before forced termination, 0 disables |
| abort | input | 1 | Force termination with a dummy last word |
| s_valid | input | 1 | User stream word valid |
| s_data | input | DW | User stream data |
| s_be | input | DW/8 | User stream byte enables, active high |
| s_last | input | 1 | User stream final word |
| s_ready | output | 1 | Sequencer accepts the stream word |
| afull_n | input | 1 | Core write FIFO almost full, active low |
| full_n | input | 1 | Core write FIFO full, active low |
| core_state | input | 3 | Core's reported master state counter |
| hdr_en_n | output | 1 | Command/address enable, active low |
| wr_en_n | output | 1 | Write-data enable, active low |
| last_n | output | 1 | Last-word marker, active low |
| dout | output | DW | Word driven to the core |
| be | output | DW/8 | Byte enables driven to the core, active high |
| seq_state | output | 3 | Local copy of the master state counter |
| state_err | output | 1 | Sticky counter mismatch flag |

## Verification
The case that matters most is a user last beat and an abort arriving in the same data-phase cycle. The bench drives `s_valid`, `s_last` and `abort` together and expects `s_ready` and `wr_en_n` to stay inactive in that cycle. It then expects the dummy last word with all byte enables off in state 4, not the user's data. A second overlap, a dummy word that falls due while the full flag is low, is provoked by aborting with `full_n` held at 0. The bench checks that the dummy word waits until the flag is released.

// File: rtl/mwr_pkg.sv
package mwr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_CMD  = 3'd1,
    ST_ADDR = 3'd2,
    ST_DATA = 3'd3,
    ST_LAST = 3'd4
  } mwr_state_t;

  // true for the states in which the write-data enable may be driven
  function automatic logic is_wr_phase(mwr_state_t s);
    return (s == ST_DATA) || (s == ST_LAST);
  endfunction

endpackage

// File: rtl/mwr_pace.sv
module mwr_pace (
  input  logic clk,
  input  logic rst_n,
  input  logic afull_n,
  input  logic full_n,
  output logic gate_ok
);
  logic thr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) thr_q <= 1'b0;
    else        thr_q <= ~afull_n;
  end

  assign gate_ok = full_n & afull_n & ~thr_q;

  // R5: the cycle after almost-full is seen, the gate is still closed
  p_afull_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!afull_n) |=> !gate_ok);
  p_full_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n) |-> !gate_ok);
endmodule

// File: rtl/mwr_idle_tmr.sv
module mwr_idle_tmr #(
  parameter int TOW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic           pending,
  input  logic [TOW-1:0] limit,
  output logic           expire
);
  logic [TOW-1:0] cnt_q;

  function automatic logic hit(logic [TOW-1:0] c, logic [TOW-1:0] lim);
    return (lim != '0) && (c == lim - TOW'(1));
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || !run || pending) cnt_q <= '0;
    else if (cnt_q != '1)          cnt_q <= cnt_q + TOW'(1);
  end

  assign expire = run && !pending && hit(cnt_q, limit);

  p_tmo_enabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> (limit != '0));
endmodule

// File: rtl/mwr_track.sv
module mwr_track (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] cur_state,
  input  logic [2:0] core_state,
  output logic       err
);
  logic [2:0] prev_q;
  logic       err_q;
  logic       diff;

  assign diff = (core_state != prev_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 3'd0;
      err_q  <= 1'b0;
    end else begin
      prev_q <= cur_state;
      err_q  <= err_q | diff;
    end
  end

  assign err = err_q;

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
  p_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    diff |=> err_q);
endmodule

// File: rtl/mwr_seq.sv
module mwr_seq
  import mwr_pkg::*;
#(
  parameter int DW  = 32,
  parameter int TOW = 8,
  localparam int BEW = DW / 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [DW-1:0]  cmd_word,
  input  logic [DW-1:0]  addr_word,
  input  logic [TOW-1:0] idle_limit,
  input  logic           abort,
  input  logic           s_valid,
  input  logic [DW-1:0]  s_data,
  input  logic [BEW-1:0] s_be,
  input  logic           s_last,
  output logic           s_ready,
  input  logic           afull_n,
  input  logic           full_n,
  input  logic [2:0]     core_state,
  output logic           hdr_en_n,
  output logic           wr_en_n,
  output logic           last_n,
  output logic [DW-1:0]  dout,
  output logic [BEW-1:0] be,
  output logic [2:0]     seq_state,
  output logic           state_err
);
  mwr_state_t st, st_nx;
  logic gate_ok, tmo, in_data, xfer, end_beat;

  mwr_pace u_pace (
    .clk(clk), .rst_n(rst_n), .afull_n(afull_n), .full_n(full_n), .gate_ok(gate_ok)
  );

  mwr_idle_tmr #(.TOW(TOW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run(in_data), .pending(s_valid),
    .limit(idle_limit), .expire(tmo)
  );

  mwr_track u_track (
    .clk(clk), .rst_n(rst_n), .cur_state(seq_state), .core_state(core_state),
    .err(state_err)
  );

  assign in_data   = (st == ST_DATA);
  assign s_ready   = in_data & gate_ok & ~abort;
  assign xfer      = s_valid & s_ready;
  assign end_beat  = xfer & s_last;
  assign seq_state = st;

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nx;
  end

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE: if (start) st_nx = ST_CMD;
      ST_CMD:  st_nx = ST_ADDR;
      ST_ADDR: st_nx = ST_DATA;
      ST_DATA: begin
        if (abort || tmo)  st_nx = ST_LAST;
        else if (end_beat) st_nx = ST_IDLE;
      end
      ST_LAST: if (gate_ok) st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_comb begin
    hdr_en_n = 1'b1;
    wr_en_n  = 1'b1;
    last_n   = 1'b1;
    dout     = '0;
    be       = '0;
    unique case (st)
      ST_CMD:  begin hdr_en_n = 1'b0; dout = cmd_word;  end
      ST_ADDR: begin hdr_en_n = 1'b0; dout = addr_word; end
      ST_DATA: begin
        wr_en_n = ~xfer;
        last_n  = ~end_beat;
        dout    = s_data;
        be      = s_be;
      end
      ST_LAST: begin
        wr_en_n = ~gate_ok;
        last_n  = ~gate_ok;
      end
      default: ;
    endcase
  end

  p_cmd_then_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CMD) |=> (st == ST_ADDR));
  p_addr_then_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ADDR) |=> (st == ST_DATA));
  p_wr_phase_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_n) |-> is_wr_phase(st));
  p_last_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_n && !last_n) |=> (st == ST_IDLE));
  p_abort_to_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && abort) |=> (st == ST_LAST));
  p_dummy_be_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LAST && !wr_en_n) |-> (be == '0 && !last_n));
  p_dummy_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LAST && wr_en_n) |=> (st == ST_LAST));
  p_start_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DATA && !abort && !tmo && !end_beat) |=> (st == ST_DATA));
endmodule

// File: tb/mwr_seq_tb.sv
module mwr_seq_tb;
  localparam int DW = 32;
  localparam int TOW = 8;
  localparam int BEW = DW / 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 0, abort = 0, s_valid = 0, s_last = 0;
  logic afull_n = 1, full_n = 1, corrupt = 0;
  logic [DW-1:0] cmd_word = 32'hC0DE_0070, addr_word = 32'h1000_2000, s_data = '0;
  logic [BEW-1:0] s_be = '0;
  logic [TOW-1:0] idle_limit = '0;
  logic [2:0] cs_q = 3'd0, core_state;
  logic s_ready, hdr_en_n, wr_en_n, last_n, state_err;
  logic [DW-1:0] dout;
  logic [BEW-1:0] be;
  logic [2:0] seq_state;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  // core model: reports the previous cycle's state
  always @(posedge clk) cs_q <= !rst_n ? 3'd0 : seq_state;
  assign core_state = corrupt ? 3'd6 : cs_q;

  mwr_seq #(.DW(DW), .TOW(TOW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_word(cmd_word), .addr_word(addr_word),
    .idle_limit(idle_limit), .abort(abort), .s_valid(s_valid), .s_data(s_data),
    .s_be(s_be), .s_last(s_last), .s_ready(s_ready), .afull_n(afull_n), .full_n(full_n),
    .core_state(core_state), .hdr_en_n(hdr_en_n), .wr_en_n(wr_en_n), .last_n(last_n),
    .dout(dout), .be(be), .seq_state(seq_state), .state_err(state_err)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // move to the next negedge, then let combinational outputs settle
  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic go_data();
    start = 1;
    step();
    start = 0;
    chk("R2 cmd state", seq_state, 1);
    chk("R2 cmd enable", hdr_en_n, 0);
    chk("R2 cmd word", dout, cmd_word);
    step();
    chk("R2 addr state", seq_state, 2);
    chk("R2 addr word", dout, addr_word);
    step();
    chk("R2 data state", seq_state, 3);
    chk("R2 header enable off", hdr_en_n, 1);
  endtask

  // {valid, last, afull_n, full_n, exp_ready, exp_wr_en_n, exp_last_n}
  localparam logic [6:0] VEC [7] = '{
    7'b1_0_1_1_1_0_1,
    7'b1_0_0_1_0_1_1,
    7'b1_0_1_1_0_1_1,
    7'b1_0_1_1_1_0_1,
    7'b1_0_1_0_0_1_1,
    7'b0_0_1_1_1_1_1,
    7'b1_1_1_1_1_0_0
  };

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    step();
    step();
    // R1 reset state
    chk("R1 state", seq_state, 0);
    chk("R1 hdr_en_n", hdr_en_n, 1);
    chk("R1 wr_en_n", wr_en_n, 1);
    chk("R1 last_n", last_n, 1);
    chk("R1 s_ready", s_ready, 0);
    chk("R1 state_err", state_err, 0);
    rst_n = 1;
    step();

    // vector walk through a burst: R3 R4 R5
    go_data();
    for (int i = 0; i < 7; i++) begin
      {s_valid, s_last, afull_n, full_n} = VEC[i][6:3];
      s_data = 32'hA000_0000 + i;
      s_be = BEW'(i + 1);
      #1;
      chk("R5 ready vector", s_ready, VEC[i][2]);
      chk("R3 wr_en_n vector", wr_en_n, VEC[i][1]);
      chk("R4 last_n vector", last_n, VEC[i][0]);
      if (!VEC[i][1]) begin
        chk("R3 data", dout, 32'hA000_0000 + i);
        chk("R3 be", be, BEW'(i + 1));
      end
      step();
    end
    s_valid = 0; s_last = 0; afull_n = 1; full_n = 1;
    #1;
    chk("R4 back to idle", seq_state, 0);

    // R10 start ignored outside idle
    go_data();
    start = 1;
    step();
    start = 0;
    chk("R10 start ignored", seq_state, 3);

    // R6 abort and last beat in the same cycle
    s_valid = 1; s_last = 1; abort = 1;
    #1;
    chk("R6 ready low on abort", s_ready, 0);
    chk("R6 no user beat", wr_en_n, 1);
    step();
    s_valid = 0; s_last = 0; abort = 0;
    #1;
    chk("R6 last state", seq_state, 4);
    chk("R6 dummy enable", wr_en_n, 0);
    chk("R6 dummy last", last_n, 0);
    chk("R6 dummy be", be, 0);
    step();
    chk("R6 idle after dummy", seq_state, 0);

    // R7 timeout of 3 idle cycles
    idle_limit = 3;
    go_data();
    step();
    chk("R7 still data 2", seq_state, 3);
    step();
    chk("R7 still data 3", seq_state, 3);
    step();
    chk("R7 timeout to last", seq_state, 4);
    chk("R7 dummy last", last_n, 0);
    step();
    chk("R7 idle", seq_state, 0);

    // R7 limit 0 disables
    idle_limit = 0;
    go_data();
    for (int k = 0; k < 20; k++) step();
    chk("R7 disabled no timeout", seq_state, 3);

    // R8 dummy held while full
    full_n = 0; abort = 1;
    step();
    abort = 0;
    chk("R8 in last", seq_state, 4);
    chk("R8 held wr_en_n", wr_en_n, 1);
    chk("R8 held last_n", last_n, 1);
    step();
    chk("R8 still last", seq_state, 4);
    full_n = 1;
    #1;
    chk("R8 released", wr_en_n, 0);
    step();
    chk("R8 idle", seq_state, 0);

    // R9 mismatch sticky
    chk("R9 clean so far", state_err, 0);
    corrupt = 1;
    step();
    corrupt = 0;
    chk("R9 flagged", state_err, 1);
    step();
    step();
    chk("R9 sticky", state_err, 1);
    rst_n = 0;
    step();
    chk("R1 err cleared by reset", state_err, 0);
    rst_n = 1;
    step();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule